// File: doc/BRIEF.md
# Multi-Channel Interval Timer with Set/Clear Control

This block is a bank of identical counting channels behind a simple word-wide register bus. Each channel owns a 16-bit up-counter, a wrap (full) compare value, a midpoint (half) compare value and a control word. The control word chooses which tick sources the channel counts and a power-of-four prescaler. A channel counts when its enable bit is set and its stop bit is clear. On reaching the full value it wraps to zero and raises its full flag. Passing the half value raises its half flag. An optional pulse-width output per channel is high while the count is at or below the half value, and it can be inverted.

Four shared registers hold the enable, stop, flag and mask bits of all channels. Software reads them at one address each and changes them only through a write-one-to-set address and a write-one-to-clear address. Each flag bit has a mask bit, and any unmasked flag drives the single interrupt line. One extra stop bit gates a separate watchdog clock, which leaves the block as an enable. The slow and external clocks arrive already synchronised, as one-cycle tick pulses.

Top module: `tmr_unit`

## Requirements
- R1: After reset the enable register reads 0, the stop register reads 0x0001_00FF, the flag register reads 0, the mask register reads 0x00FF_00FF, every full- and half-compare register reads 0xFFFF, every counter reads 0, and irq, wdt_clk_en and all PWM pins are low.
- R2: A write to a set alias (enable 0x14, stop 0x2C, flag 0x24, mask 0x34) sets exactly the register bits that are one in the byte-strobed write data. A write to a clear alias (enable 0x18, stop 0x3C, flag 0x28, mask 0x38) clears exactly those bits. Reads come from 0x10, 0x1C, 0x20 and 0x30.
- R3: Writes to the read addresses 0x10, 0x1C, 0x20 and 0x30 change nothing.
- R4: Channel n (window 0x40+0x10·n: full +0x0, half +0x4, counter +0x8, control +0xC) advances only while enable bit n is 1 and stop bit n is 0. Otherwise its counter holds.
- R5: On a counting tick where the counter equals the full-compare value, the counter becomes 0 and flag bit n sets. The count sequence is therefore 0..full, and the period is full+1 ticks.
- R6: On a counting tick where the counter equals the half-compare value, flag bit n+16 sets.
- R7: Control bits [5:3] select the prescaler: code k (0..5) gives one count per 4^k source ticks, counted from the moment the channel starts running.
- R8: Control bit 0 counts every bus clock, bit 1 counts rtc_tick pulses and bit 2 counts ext_tick pulses. With no source bit set, the channel does not count.
- R9: irq is high exactly when some flag bit is 1 and its mask bit is 0.
- R10: A flag bit that hardware sets in the same cycle as a clear-alias write to that bit stays 1.
- R11: With control bit 7 set, pwm_out[n] is 1 while counter ≤ half-compare and 0 otherwise. Control bit 8 inverts the pin. With bit 7 clear, the pin sits at the level of bit 8.
- R12: wdt_clk_en is the inverse of stop bit 16.
- R13: A write to a counter loads the written value on that clock edge, even while the channel is counting. It takes priority over the tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counting clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_be | input | 4 | Byte lane strobes for the write data |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| rtc_tick | input | 1 | Synchronised one-cycle slow clock tick |
| ext_tick | input | 1 | Synchronised one-cycle external clock tick |
| irq | output | 1 | Combined interrupt |
| wdt_clk_en | output | 1 | Watchdog clock enable |
| pwm_out | output | NUM_CH | Per-channel pulse-width outputs |

## Verification
Two events can hit the same flag bit in one clock: a hardware compare hit sets it, and a clear-alias write clears it. The bench provokes this with a channel whose full value is 0 on the bus clock, so that channel hits on every cycle. It writes the clear alias to that channel's flag and expects the bit still set. It then stops the channel and expects the same write to clear the bit. A second collision is a software counter write landing on a counting tick. The bench writes zero to a running counter and expects the count measured from that edge, with no extra increment.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   // shared register addresses (read, set alias, clear alias)
   localparam logic [7:0] A_EN       = 8'h10;
   localparam logic [7:0] A_EN_SET   = 8'h14;
   localparam logic [7:0] A_EN_CLR   = 8'h18;
   localparam logic [7:0] A_STOP     = 8'h1C;
   localparam logic [7:0] A_STOP_SET = 8'h2C;
   localparam logic [7:0] A_STOP_CLR = 8'h3C;
   localparam logic [7:0] A_FLAG     = 8'h20;
   localparam logic [7:0] A_FLAG_SET = 8'h24;
   localparam logic [7:0] A_FLAG_CLR = 8'h28;
   localparam logic [7:0] A_MASK     = 8'h30;
   localparam logic [7:0] A_MASK_SET = 8'h34;
   localparam logic [7:0] A_MASK_CLR = 8'h38;

   // channel windows
   localparam int         CH_BASE   = 64;
   localparam int         CH_SPAN   = 16;
   localparam logic [3:0] OFS_FULL  = 4'h0;
   localparam logic [3:0] OFS_HALF  = 4'h4;
   localparam logic [3:0] OFS_CNT   = 4'h8;
   localparam logic [3:0] OFS_CTRL  = 4'hC;

   localparam int WDT_BIT    = 16;
   localparam int HALF_SHIFT = 16;
   localparam int REG_W      = 16;

   typedef struct packed {
      logic       pwm_low;
      logic       pwm_en;
      logic       rsvd;
      logic [2:0] ps;
      logic       src_ext;
      logic       src_rtc;
      logic       src_bus;
   } ch_ctrl_t;

   localparam int CTRL_W = $bits(ch_ctrl_t);

   function automatic logic [31:0] lane_mask(input logic [3:0] be);
      logic [31:0] m;
      m = '0;
      for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{be[i]}};
      return m;
   endfunction

endpackage

// File: rtl/tmr_setclr_reg.sv
module tmr_setclr_reg #(
   parameter int           W       = 32,
   parameter logic [W-1:0] IMPL    = '1,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_stb,
   input  logic         clr_stb,
   input  logic [W-1:0] wd,
   input  logic [W-1:0] hw_set,
   output logic [W-1:0] q
);

   logic [W-1:0] set_v;
   logic [W-1:0] clr_v;
   logic [W-1:0] q_nx;

   // hardware set is applied after the clear so a same-cycle hit survives
   always_comb begin
      set_v = set_stb ? wd : '0;
      clr_v = clr_stb ? wd : '0;
      q_nx  = ((q & ~clr_v) | set_v | hw_set) & IMPL;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST_VAL & IMPL;
      else        q <= q_nx;
   end

endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
   parameter int MAX_CODE = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       src_tick,
   input  logic [2:0] code,
   output logic       tick
);

   localparam int PS_W = (MAX_CODE > 0) ? 2 * MAX_CODE : 1;

   generate
      if (MAX_CODE == 0) begin : g_bypass
         logic unused_code;
         assign unused_code = ^code;
         assign tick = run & src_tick;
      end else begin : g_div
         logic [PS_W-1:0] ps_q;
         logic [2:0]      eff;
         logic [PS_W-1:0] need;

         // codes above the supported range clamp to the largest divider
         always_comb begin
            eff  = (code > 3'(MAX_CODE)) ? 3'(MAX_CODE) : code;
            need = '0;
            for (int k = 0; k < MAX_CODE; k++)
               if (k < int'(eff)) need[2*k +: 2] = 2'b11;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        ps_q <= '0;
            else if (!run)     ps_q <= '0;
            else if (src_tick) ps_q <= ps_q + 1'b1;
         end

         assign tick = run & src_tick & ((ps_q & need) == need);
      end
   endgenerate

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
   import tmr_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int MAX_PS_CODE = 5,
   parameter bit HAS_PWM     = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             rtc_tick,
   input  logic             ext_tick,
   input  logic             wr_full,
   input  logic             wr_half,
   input  logic             wr_cnt,
   input  logic             wr_ctrl,
   input  logic [REG_W-1:0] wd,
   input  logic [REG_W-1:0] bm,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] full_cmp,
   output logic [CNT_W-1:0] half_cmp,
   output ch_ctrl_t         ctrl,
   output logic             hit_full,
   output logic             hit_half,
   output logic             pwm
);

   logic [CNT_W-1:0] cnt_q, full_q, half_q;
   logic [CNT_W-1:0] wd_c, bm_c;
   ch_ctrl_t         ctrl_q, ctrl_nx;
   logic             src_tick, cnt_tick, at_full, at_half;

   assign wd_c = wd[CNT_W-1:0];
   assign bm_c = bm[CNT_W-1:0];

   always_comb begin
      ctrl_nx      = ch_ctrl_t'((ctrl_q & ~bm[CTRL_W-1:0]) | (wd[CTRL_W-1:0] & bm[CTRL_W-1:0]));
      ctrl_nx.rsvd = 1'b0;
   end

   generate
      if (CNT_W < REG_W) begin : g_unused_hi
         logic unused_hi;
         assign unused_hi = ^{wd[REG_W-1:CNT_W], bm[REG_W-1:CNT_W]};
      end
   endgenerate

   // compare and control registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q <= '1;
         half_q <= '1;
         ctrl_q <= '0;
      end else begin
         if (wr_full) full_q <= (full_q & ~bm_c) | (wd_c & bm_c);
         if (wr_half) half_q <= (half_q & ~bm_c) | (wd_c & bm_c);
         if (wr_ctrl) ctrl_q <= ctrl_nx;
      end
   end

   assign src_tick = ctrl_q.src_bus
                   | (ctrl_q.src_rtc & rtc_tick)
                   | (ctrl_q.src_ext & ext_tick);

   tmr_prescale #(.MAX_CODE(MAX_PS_CODE)) u_ps (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .src_tick (src_tick),
      .code     (ctrl_q.ps),
      .tick     (cnt_tick)
   );

   assign at_full = (cnt_q == full_q);
   assign at_half = (cnt_q == half_q);

   // software load wins over a counting tick
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (wr_cnt)   cnt_q <= (cnt_q & ~bm_c) | (wd_c & bm_c);
      else if (cnt_tick) cnt_q <= at_full ? '0 : cnt_q + 1'b1;
   end

   assign hit_full = cnt_tick & at_full;
   assign hit_half = cnt_tick & at_half;

   generate
      if (HAS_PWM) begin : g_pwm
         assign pwm = ctrl_q.pwm_en ? ((cnt_q <= half_q) ^ ctrl_q.pwm_low) : ctrl_q.pwm_low;
      end else begin : g_no_pwm
         assign pwm = 1'b0;
      end
   endgenerate

   assign cnt      = cnt_q;
   assign full_cmp = full_q;
   assign half_cmp = half_q;
   assign ctrl     = ctrl_q;

endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
   import tmr_pkg::*;
#(
   parameter int NUM_CH      = 8,
   parameter int CNT_W       = 16,
   parameter int MAX_PS_CODE = 5,
   parameter bit HAS_PWM     = 1'b1,
   localparam int ADDR_W     = $clog2(CH_BASE + CH_SPAN * NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [3:0]        bus_be,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              rtc_tick,
   input  logic              ext_tick,
   output logic              irq,
   output logic              wdt_clk_en,
   output logic [NUM_CH-1:0] pwm_out
);

   localparam logic [31:0] CH_BITS   = (32'd1 << NUM_CH) - 32'd1;
   localparam logic [31:0] EN_IMPL   = CH_BITS;
   localparam logic [31:0] STOP_IMPL = CH_BITS | (32'd1 << WDT_BIT);
   localparam logic [31:0] FLAG_IMPL = CH_BITS | (CH_BITS << HALF_SHIFT);
   localparam int          CH_END    = CH_BASE + CH_SPAN * NUM_CH;
   localparam int          IDX_W     = ADDR_W - 4;

   // elaboration-time parameter checks
   generate
      if (NUM_CH < 1 || NUM_CH > 16) begin : g_bad_num_ch
         $error("tmr_unit: NUM_CH must lie in 1..16");
      end
      if (CNT_W < CTRL_W || CNT_W > REG_W) begin : g_bad_cnt_w
         $error("tmr_unit: CNT_W must lie in 9..16");
      end
      if (MAX_PS_CODE < 0 || MAX_PS_CODE > 7) begin : g_bad_ps
         $error("tmr_unit: MAX_PS_CODE must lie in 0..7");
      end
   endgenerate

   logic [31:0]       wdm;
   logic [31:0]       en_q, stop_q, flag_q, mask_q, hw_flag;
   logic [NUM_CH-1:0] run_vec, hit_f, hit_h;
   logic [NUM_CH*CNT_W-1:0] cnt_flat;
   logic              in_ch;
   logic [IDX_W-1:0]  ch_idx;
   logic [3:0]        ofs;

   logic [CNT_W-1:0]  cnt_a  [NUM_CH];
   logic [CNT_W-1:0]  full_a [NUM_CH];
   logic [CNT_W-1:0]  half_a [NUM_CH];
   ch_ctrl_t          ctrl_a [NUM_CH];

   assign wdm = bus_wdata & lane_mask(bus_be);

   function automatic logic wr_at(input logic [7:0] a);
      return bus_we && (bus_addr == ADDR_W'(a));
   endfunction

   // shared registers
   tmr_setclr_reg #(.W(32), .IMPL(EN_IMPL), .RST_VAL(32'h0)) u_en (
      .clk(clk), .rst_n(rst_n), .set_stb(wr_at(A_EN_SET)), .clr_stb(wr_at(A_EN_CLR)),
      .wd(wdm), .hw_set(32'h0), .q(en_q));

   tmr_setclr_reg #(.W(32), .IMPL(STOP_IMPL), .RST_VAL(32'hFFFF_FFFF)) u_stop (
      .clk(clk), .rst_n(rst_n), .set_stb(wr_at(A_STOP_SET)), .clr_stb(wr_at(A_STOP_CLR)),
      .wd(wdm), .hw_set(32'h0), .q(stop_q));

   tmr_setclr_reg #(.W(32), .IMPL(FLAG_IMPL), .RST_VAL(32'h0)) u_flag (
      .clk(clk), .rst_n(rst_n), .set_stb(wr_at(A_FLAG_SET)), .clr_stb(wr_at(A_FLAG_CLR)),
      .wd(wdm), .hw_set(hw_flag), .q(flag_q));

   tmr_setclr_reg #(.W(32), .IMPL(FLAG_IMPL), .RST_VAL(32'hFFFF_FFFF)) u_mask (
      .clk(clk), .rst_n(rst_n), .set_stb(wr_at(A_MASK_SET)), .clr_stb(wr_at(A_MASK_CLR)),
      .wd(wdm), .hw_set(32'h0), .q(mask_q));

   // channel window decode
   assign in_ch  = (int'(bus_addr) >= CH_BASE) && (int'(bus_addr) < CH_END);
   assign ch_idx = bus_addr[ADDR_W-1:4] - IDX_W'(CH_BASE / CH_SPAN);
   assign ofs    = bus_addr[3:0];

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
         logic sel;
         assign sel        = bus_we && in_ch && (ch_idx == IDX_W'(i));
         assign run_vec[i] = en_q[i] & ~stop_q[i];

         tmr_channel #(
            .CNT_W       (CNT_W),
            .MAX_PS_CODE (MAX_PS_CODE),
            .HAS_PWM     (HAS_PWM)
         ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (run_vec[i]),
            .rtc_tick (rtc_tick),
            .ext_tick (ext_tick),
            .wr_full  (sel && ofs == OFS_FULL),
            .wr_half  (sel && ofs == OFS_HALF),
            .wr_cnt   (sel && ofs == OFS_CNT),
            .wr_ctrl  (sel && ofs == OFS_CTRL),
            .wd       (wdm[REG_W-1:0]),
            .bm       (lane_mask(bus_be) & 32'h0000_FFFF),
            .cnt      (cnt_a[i]),
            .full_cmp (full_a[i]),
            .half_cmp (half_a[i]),
            .ctrl     (ctrl_a[i]),
            .hit_full (hit_f[i]),
            .hit_half (hit_h[i]),
            .pwm      (pwm_out[i])
         );

         assign cnt_flat[i*CNT_W +: CNT_W] = cnt_a[i];
      end
   endgenerate

   assign hw_flag = 32'(hit_f) | (32'(hit_h) << HALF_SHIFT);

   // read path
   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(A_EN))        bus_rdata = en_q;
      else if (bus_addr == ADDR_W'(A_STOP)) bus_rdata = stop_q;
      else if (bus_addr == ADDR_W'(A_FLAG)) bus_rdata = flag_q;
      else if (bus_addr == ADDR_W'(A_MASK)) bus_rdata = mask_q;
      else if (in_ch) begin
         for (int i = 0; i < NUM_CH; i++) begin
            if (ch_idx == IDX_W'(i)) begin
               case (ofs)
                  OFS_FULL: bus_rdata = 32'(full_a[i]);
                  OFS_HALF: bus_rdata = 32'(half_a[i]);
                  OFS_CNT:  bus_rdata = 32'(cnt_a[i]);
                  OFS_CTRL: bus_rdata = 32'(ctrl_a[i]);
                  default:  bus_rdata = '0;
               endcase
            end
         end
      end
   end

   assign irq        = |(flag_q & ~mask_q);
   assign wdt_clk_en = ~stop_q[WDT_BIT];

endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk
   import tmr_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 8
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    bus_we,
   input logic [ADDR_W-1:0]       bus_addr,
   input logic [3:0]              bus_be,
   input logic [31:0]             bus_wdata,
   input logic                    irq,
   input logic                    wdt_clk_en,
   input logic [31:0]             en_q,
   input logic [31:0]             stop_q,
   input logic [31:0]             flag_q,
   input logic [31:0]             mask_q,
   input logic [31:0]             hw_flag,
   input logic [NUM_CH*CNT_W-1:0] cnt_flat,
   input logic [NUM_CH-1:0]       run_vec
);

   localparam logic [31:0] CH_BITS = (32'd1 << NUM_CH) - 32'd1;
   localparam logic [31:0] FL_IMPL = CH_BITS | (CH_BITS << HALF_SHIFT);

   logic [31:0] wdm, wdm_f, wdm_e;
   assign wdm   = bus_wdata & lane_mask(bus_be);
   assign wdm_f = wdm & FL_IMPL;
   assign wdm_e = wdm & CH_BITS;

   p_direct_en_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(A_EN)) |=> $stable(en_q));

   p_direct_mask_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(A_MASK)) |=> $stable(mask_q));

   p_mask_set_alias_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(A_MASK_SET)) |=> ((mask_q & $past(wdm_f)) == $past(wdm_f)));

   p_en_clr_alias_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(A_EN_CLR)) |=> ((en_q & $past(wdm_e)) == 32'h0));

   p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_flag != 32'h0) |=> ((flag_q & $past(hw_flag)) == $past(hw_flag)));

   p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((flag_q & ~mask_q) == 32'h0) |-> !irq);

   p_wdt_on_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(A_STOP_CLR) && bus_wdata[WDT_BIT] && bus_be[2]) |=> wdt_clk_en);

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_frz
         logic cnt_wr;
         assign cnt_wr = bus_we && (int'(bus_addr) == CH_BASE + CH_SPAN * i + 8);
         p_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!run_vec[i] && !cnt_wr) |=> $stable(cnt_flat[i*CNT_W +: CNT_W]));
      end
   endgenerate

endmodule

bind tmr_unit tmr_unit_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tmr_unit_test.sv
module tmr_unit_test;
   import tmr_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int NCH        = 8;
   localparam logic [31:0] EN_IMP   = 32'h0000_00FF;
   localparam logic [31:0] STOP_IMP = 32'h0001_00FF;
   localparam logic [31:0] FLAG_IMP = 32'h00FF_00FF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [3:0]  bus_be = 4'hF;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        rtc_tick = 1'b0;
   logic        ext_tick = 1'b0;
   logic        irq;
   logic        wdt_clk_en;
   logic [NCH-1:0] pwm_out;

   int tests = 0;
   int fails = 0;

   tmr_unit #(.NUM_CH(NCH)) uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_be(bus_be),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rtc_tick(rtc_tick), .ext_tick(ext_tick),
      .irq(irq), .wdt_clk_en(wdt_clk_en), .pwm_out(pwm_out));

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [7:0] ch_a(input int ch, input logic [3:0] ofs);
      return 8'(CH_BASE + CH_SPAN * ch + int'(ofs));
   endfunction

   function automatic logic [31:0] lanes(input logic [3:0] be);
      logic [31:0] m;
      for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{be[i]}};
      return m;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // called at a falling edge; the write lands on the next rising edge
   task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
      bus_addr = a; bus_wdata = d; bus_be = be; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0; bus_be = 4'hF;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_ext(input int n);
      repeat (n) begin ext_tick = 1'b1; @(negedge clk); ext_tick = 1'b0; @(negedge clk); end
   endtask

   task automatic pulse_rtc(input int n);
      repeat (n) begin rtc_tick = 1'b1; @(negedge clk); rtc_tick = 1'b0; @(negedge clk); end
   endtask

   task automatic summary;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] v;
      logic [31:0] en_m, stop_m, mask_m;
      void'($urandom(32'd20240611));

      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      rd(A_EN, v);   check("R1 enable", v, 32'h0);
      rd(A_STOP, v); check("R1 stop", v, 32'h0001_00FF);
      rd(A_FLAG, v); check("R1 flag", v, 32'h0);
      rd(A_MASK, v); check("R1 mask", v, 32'h00FF_00FF);
      rd(ch_a(3, OFS_FULL), v); check("R1 full cmp", v, 32'hFFFF);
      rd(ch_a(3, OFS_HALF), v); check("R1 half cmp", v, 32'hFFFF);
      rd(ch_a(3, OFS_CNT), v);  check("R1 counter", v, 32'h0);
      check("R1 pins", {29'h0, irq, wdt_clk_en, |pwm_out}, 32'h0);

      // R3 writes to the read addresses are ignored
      wr(A_EN, 32'hFFFF_FFFF);   rd(A_EN, v);   check("R3 enable direct", v, 32'h0);
      wr(A_STOP, 32'h0);         rd(A_STOP, v); check("R3 stop direct", v, STOP_IMP);
      wr(A_FLAG, 32'hFFFF_FFFF); rd(A_FLAG, v); check("R3 flag direct", v, 32'h0);
      wr(A_MASK, 32'h0);         rd(A_MASK, v); check("R3 mask direct", v, FLAG_IMP);

      // R2 constrained random set/clear traffic with byte strobes
      en_m = 32'h0; stop_m = STOP_IMP; mask_m = FLAG_IMP;
      for (int it = 0; it < 300; it++) begin
         int g, op;
         logic [31:0] d, wd;
         logic [3:0]  be;
         logic [7:0]  a, ra;
         g  = $urandom_range(0, 2);
         op = $urandom_range(0, 3);
         d  = $urandom;
         be = 4'($urandom);
         wd = d & lanes(be);
         case (g)
            0: begin ra = A_EN;   a = (op == 0) ? A_EN_SET   : (op == 1) ? A_EN_CLR   : A_EN; end
            1: begin ra = A_STOP; a = (op == 0) ? A_STOP_SET : (op == 1) ? A_STOP_CLR : A_STOP; end
            default: begin ra = A_MASK; a = (op == 0) ? A_MASK_SET : (op == 1) ? A_MASK_CLR : A_MASK; end
         endcase
         wr(a, d, be);
         if (op == 0) begin
            if (g == 0) en_m |= wd & EN_IMP; else if (g == 1) stop_m |= wd & STOP_IMP; else mask_m |= wd & FLAG_IMP;
         end else if (op == 1) begin
            if (g == 0) en_m &= ~wd; else if (g == 1) stop_m &= ~wd; else mask_m &= ~wd;
         end
         rd(ra, v);
         check((op >= 2) ? "R3 random direct write" : "R2 random alias write",
               v, (g == 0) ? en_m : (g == 1) ? stop_m : mask_m);
      end
      wr(A_EN_CLR, 32'hFFFF_FFFF);
      wr(A_STOP_SET, 32'hFFFF_FFFF);
      wr(A_MASK_SET, 32'hFFFF_FFFF);

      // R4 channel 0 on bus clock: needs enable and not stop
      wr(ch_a(0, OFS_CTRL), 32'h1);
      wr(ch_a(0, OFS_CNT), 32'h0);
      wr(A_STOP_CLR, 32'h1);
      idle(10);
      rd(ch_a(0, OFS_CNT), v); check("R4 not enabled holds", v, 32'd0);
      wr(A_EN_SET, 32'h1);
      idle(20);
      rd(ch_a(0, OFS_CNT), v); check("R4 R8 bus clock count", v, 32'd20);
      wr(A_STOP_SET, 32'h1);
      idle(5);
      rd(ch_a(0, OFS_CNT), v); check("R4 stopped holds", v, 32'd21);

      // R7 prescalers: ch1 /16, ch2 /4, ch3 /1024
      wr(ch_a(1, OFS_CTRL), 32'h11);
      wr(ch_a(2, OFS_CTRL), 32'h09);
      wr(ch_a(3, OFS_CTRL), 32'h29);
      wr(A_STOP_CLR, 32'hE);
      wr(A_EN_SET, 32'hE);
      idle(37);
      rd(ch_a(2, OFS_CNT), v); check("R7 div4 at 37", v, 32'd9);
      idle(63);
      rd(ch_a(1, OFS_CNT), v); check("R7 div16 at 100", v, 32'd6);
      rd(ch_a(2, OFS_CNT), v); check("R7 div4 at 100", v, 32'd25);
      idle(2000);
      rd(ch_a(3, OFS_CNT), v); check("R7 div1024 at 2100", v, 32'd2);
      rd(ch_a(1, OFS_CNT), v); check("R7 div16 at 2100", v, 32'd131);
      wr(A_EN_CLR, 32'hE);

      // R8 source selection on ch4
      wr(ch_a(4, OFS_CTRL), 32'h4);
      wr(A_STOP_CLR, 32'h10);
      wr(A_EN_SET, 32'h10);
      idle(10);
      rd(ch_a(4, OFS_CNT), v); check("R8 ext idle", v, 32'd0);
      pulse_ext(7);
      rd(ch_a(4, OFS_CNT), v); check("R8 ext pulses", v, 32'd7);
      pulse_rtc(3);
      rd(ch_a(4, OFS_CNT), v); check("R8 rtc not selected", v, 32'd7);
      wr(ch_a(4, OFS_CTRL), 32'h2);
      pulse_rtc(3);
      pulse_ext(2);
      rd(ch_a(4, OFS_CNT), v); check("R8 rtc selected", v, 32'd10);
      wr(A_STOP_SET, 32'h10);

      // R5 full compare on ch5, R6 half compare on ch6
      wr(ch_a(5, OFS_FULL), 32'd4);
      wr(ch_a(5, OFS_CTRL), 32'h1);
      wr(ch_a(6, OFS_HALF), 32'd5);
      wr(ch_a(6, OFS_CTRL), 32'h1);
      wr(A_STOP_CLR, 32'h60);
      wr(A_EN_SET, 32'h60);
      idle(4);
      rd(ch_a(5, OFS_CNT), v); check("R5 at full", v, 32'd4);
      rd(A_FLAG, v);           check("R5 flag before wrap", v & 32'h0000_0020, 32'h0);
      idle(1);
      rd(ch_a(5, OFS_CNT), v); check("R5 wrapped", v, 32'd0);
      rd(A_FLAG, v);           check("R5 flag after wrap", v & 32'h0000_0020, 32'h20);
      rd(ch_a(6, OFS_CNT), v); check("R6 at half", v, 32'd5);
      rd(A_FLAG, v);           check("R6 half flag not yet", v & 32'h0040_0000, 32'h0);
      idle(1);
      rd(A_FLAG, v);           check("R6 half flag set", v & 32'h0060_0040, 32'h0040_0000);
      idle(7);
      rd(ch_a(5, OFS_CNT), v); check("R5 period of five", v, 32'd3);
      wr(A_STOP_SET, 32'h60);

      // R9 interrupt masking
      check("R9 all masked", {31'h0, irq}, 32'h0);
      wr(A_MASK_CLR, 32'h0040_0000);
      check("R9 unmasked flag", {31'h0, irq}, 32'h1);
      wr(A_FLAG_CLR, 32'h0040_0000);
      rd(A_FLAG, v); check("R2 flag clear alias", v & 32'h0040_0000, 32'h0);
      check("R9 flag cleared", {31'h0, irq}, 32'h0);
      wr(A_FLAG_SET, 32'h0040_0000);
      check("R9 R2 flag set alias", {31'h0, irq}, 32'h1);
      wr(A_MASK_SET, 32'h0040_0000);
      check("R9 remasked", {31'h0, irq}, 32'h0);

      // R10 hardware set wins over a clear-alias write
      wr(ch_a(7, OFS_FULL), 32'd0);
      wr(ch_a(7, OFS_CTRL), 32'h1);
      wr(A_STOP_CLR, 32'h80);
      wr(A_EN_SET, 32'h80);
      idle(2);
      wr(A_FLAG_CLR, 32'h80);
      rd(A_FLAG, v); check("R10 collision keeps flag", v & 32'h80, 32'h80);
      wr(A_STOP_SET, 32'h80);
      wr(A_FLAG_CLR, 32'h80);
      rd(A_FLAG, v); check("R10 clear without hit", v & 32'h80, 32'h0);

      // R11 PWM on stopped ch0 (count 21)
      wr(ch_a(0, OFS_HALF), 32'd30);
      wr(ch_a(0, OFS_CTRL), 32'h81);
      check("R11 below half", {31'h0, pwm_out[0]}, 32'h1);
      wr(ch_a(0, OFS_HALF), 32'd21);
      check("R11 equal half", {31'h0, pwm_out[0]}, 32'h1);
      wr(ch_a(0, OFS_HALF), 32'd20);
      check("R11 above half", {31'h0, pwm_out[0]}, 32'h0);
      wr(ch_a(0, OFS_CTRL), 32'h181);
      check("R11 inverted above half", {31'h0, pwm_out[0]}, 32'h1);
      wr(ch_a(0, OFS_HALF), 32'd30);
      check("R11 inverted below half", {31'h0, pwm_out[0]}, 32'h0);
      wr(ch_a(0, OFS_CTRL), 32'h101);
      check("R11 disabled idles at polarity", {31'h0, pwm_out[0]}, 32'h1);
      rd(ch_a(0, OFS_CTRL), v); check("R11 control readback", v, 32'h101);

      // R13 counter load while running
      wr(ch_a(0, OFS_CTRL), 32'h1);
      wr(A_STOP_CLR, 32'h1);
      idle(4);
      wr(ch_a(0, OFS_CNT), 32'd0);
      idle(3);
      rd(ch_a(0, OFS_CNT), v); check("R13 load beats tick", v, 32'd3);
      wr(A_STOP_SET, 32'h1);

      // R12 watchdog clock gate
      wr(A_STOP_CLR, 32'h0001_0000);
      check("R12 watchdog running", {31'h0, wdt_clk_en}, 32'h1);
      wr(A_STOP_SET, 32'h0001_0000);
      check("R12 watchdog gated", {31'h0, wdt_clk_en}, 32'h0);

      summary();
      $finish;
   end

endmodule